// File: doc/BRIEF.md
# Text Hex Request Decoder

This block sits behind a serial receiver and turns a stream of printable characters into bus requests. Each byte arrives with a one-cycle strobe. A message opens with a letter that selects the operation: `R` reads and `W` writes. Four hexadecimal characters follow as the address. A write then carries four more hexadecimal characters of data. A carriage return and a line feed close the message. When the closing line feed is accepted, the block raises a one-cycle request strobe. The address, the write data and the direction are presented alongside it.

Any character that does not fit the expected position abandons the message, and the decoder goes back to waiting for an operation letter. An operation letter that appears in the middle of a message starts a new message at once. The host can therefore recover from a corrupted line simply by sending the next request. Read responses, the serial link and the downstream bus are handled by other blocks.

Top module: `hexreq_parser`

## Requirements
- R1: While waiting for a message, any byte other than `R` (0x52) or `W` (0x57) is ignored and produces no request.
- R2: The address is taken from exactly four hex characters that follow the operation letter, most significant nibble first.
- R3: A `W` message carries four hex data characters after the address, most significant first, and reports `req_write`=1. An `R` message carries no data, reports `req_write`=0, and presents `req_wdata`=0.
- R4: Only 0x30..0x39 (`0`..`9`) and 0x41..0x46 (`A`..`F`) count as hex characters. Any other byte in a hex position, lower-case letters included, drops the message.
- R5: After the last hex character, the byte 0x0D and then the byte 0x0A must follow. Any other byte in either position drops the message.
- R6: An `R` or `W` received at any point inside a message discards the partial message and starts a new one of the new type.
- R7: `req_valid` is high for exactly one clock, in the cycle after the line feed is accepted. `req_addr`, `req_wdata` and `req_write` hold the decoded values during that cycle.
- R8: A byte is consumed only in a cycle where `rx_valid` is high. Bytes presented while it is low have no effect.
- R9: While reset is asserted, and after it is released, `req_valid` is low and the decoder waits for an operation letter. A message that was partly received is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_byte | input | 8 | Received character |
| rx_valid | input | 1 | Strobe: `rx_byte` is valid this cycle |
| req_valid | output | 1 | One-cycle request strobe |
| req_write | output | 1 | 1 for a write request, 0 for a read request |
| req_addr | output | 16 | Decoded request address |
| req_wdata | output | 16 | Decoded write data (zero for a read) |

## Verification
The bench sends lower-case hex such as `a`. A decoder that folded case would accept it and issue a request the host never formed. The bench also puts an operation letter in the middle of a message. A decoder that treated that letter as garbage would lose the second request, and one that kept the old shift contents would issue it with a blended address. Some streams carry a lone line feed, a doubled carriage return, or a byte held while the strobe is low. A decoder that ignored the framing or the strobe would issue a request on these. The bench also checks that a read reports zero data and that the strobe is one cycle wide. A stale data register or a request flag that is not cleared would show up there.

// File: rtl/hexreq_pkg.sv
package hexreq_pkg;

  typedef enum logic [2:0] {
    CK_OTHER,
    CK_HEX,
    CK_CR,
    CK_LF,
    CK_RD,
    CK_WR
  } chr_kind_t;

  typedef enum logic [2:0] {
    PS_WAIT,
    PS_ADDR,
    PS_DATA,
    PS_CR,
    PS_LF
  } pstate_t;

  localparam logic [7:0] CH_RD = 8'h52;
  localparam logic [7:0] CH_WR = 8'h57;
  localparam logic [7:0] CH_CR = 8'h0D;
  localparam logic [7:0] CH_LF = 8'h0A;

endpackage

// File: rtl/hexreq_classify.sv
module hexreq_classify
  import hexreq_pkg::*;
(
  input  logic [7:0] chr,
  output chr_kind_t  kind,
  output logic [3:0] nib
);

  logic is_dec;
  logic is_ucx;

  always_comb begin
    is_dec = (chr >= 8'h30) && (chr <= 8'h39);
    is_ucx = (chr >= 8'h41) && (chr <= 8'h46);
    nib    = 4'h0;
    kind   = CK_OTHER;
    if (is_dec) begin
      kind = CK_HEX;
      nib  = chr[3:0];
    end else if (is_ucx) begin
      kind = CK_HEX;
      nib  = chr[3:0] + 4'd9;
    end else if (chr == CH_CR) begin
      kind = CK_CR;
    end else if (chr == CH_LF) begin
      kind = CK_LF;
    end else if (chr == CH_RD) begin
      kind = CK_RD;
    end else if (chr == CH_WR) begin
      kind = CK_WR;
    end
  end

endmodule

// File: rtl/hexreq_fsm.sv
module hexreq_fsm
  import hexreq_pkg::*;
#(
  parameter int A_NIBS = 4,
  parameter int D_NIBS = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      byte_en,
  input  chr_kind_t kind,
  output logic      sh_addr,
  output logic      sh_data,
  output logic      clr,
  output logic      is_wr,
  output logic      fire
);

  localparam int MAX_N = (A_NIBS > D_NIBS) ? A_NIBS : D_NIBS;
  localparam int CNT_W = (MAX_N > 2) ? $clog2(MAX_N) : 1;
  localparam logic [CNT_W-1:0] A_LAST = CNT_W'(A_NIBS - 1);
  localparam logic [CNT_W-1:0] D_LAST = CNT_W'(D_NIBS - 1);

  pstate_t          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_q, wr_d;
  logic             fire_q, fire_d;
  logic             st_en;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    wr_d    = wr_q;
    fire_d  = 1'b0;
    sh_addr = 1'b0;
    sh_data = 1'b0;
    clr     = 1'b0;
    if (byte_en) begin
      if (kind == CK_RD || kind == CK_WR) begin
        st_d  = PS_ADDR;
        cnt_d = '0;
        wr_d  = (kind == CK_WR);
        clr   = 1'b1;
      end else begin
        case (st_q)
          PS_ADDR: begin
            if (kind == CK_HEX) begin
              sh_addr = 1'b1;
              if (cnt_q == A_LAST) begin
                cnt_d = '0;
                st_d  = wr_q ? PS_DATA : PS_CR;
              end else begin
                cnt_d = cnt_q + 1'b1;
              end
            end else begin
              st_d = PS_WAIT;
            end
          end
          PS_DATA: begin
            if (kind == CK_HEX) begin
              sh_data = 1'b1;
              if (cnt_q == D_LAST) begin
                cnt_d = '0;
                st_d  = PS_CR;
              end else begin
                cnt_d = cnt_q + 1'b1;
              end
            end else begin
              st_d = PS_WAIT;
            end
          end
          PS_CR: st_d = (kind == CK_CR) ? PS_LF : PS_WAIT;
          PS_LF: begin
            fire_d = (kind == CK_LF);
            st_d   = PS_WAIT;
          end
          default: st_d = PS_WAIT;
        endcase
      end
    end
  end

  assign st_en = byte_en | fire_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_WAIT;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= fire_d;
      if (st_en) begin
        st_q  <= st_d;
        cnt_q <= cnt_d;
        wr_q  <= wr_d;
      end
    end
  end

  assign is_wr = wr_q;
  assign fire  = fire_q;

endmodule

// File: rtl/hexreq_shift.sv
module hexreq_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift,
  input  logic [3:0]   nib,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r, q_d;
  logic         en;

  generate
    if (W > 4) begin : g_wide
      always_comb q_d = clr ? '0 : {q_r[W-5:0], nib};
    end else begin : g_narrow
      always_comb q_d = clr ? '0 : W'(nib);
    end
  endgenerate

  assign en = clr | shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (en) q_r <= q_d;
  end

  assign q = q_r;

endmodule

// File: rtl/hexreq_parser.sv
module hexreq_parser
  import hexreq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int RST_SYN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        rx_byte,
  input  logic              rx_valid,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata
);

  localparam int A_NIBS = ADDR_W / 4;
  localparam int D_NIBS = DATA_W / 4;

  logic [RST_SYN-1:0] rsync;
  logic               rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[RST_SYN-2:0], 1'b1};
  end
  assign rst_int_n = rsync[RST_SYN-1];

  chr_kind_t  kind;
  logic [3:0] nib;
  logic       sh_a, sh_d, clr;

  hexreq_classify u_cls (
    .chr  (rx_byte),
    .kind (kind),
    .nib  (nib)
  );

  hexreq_fsm #(.A_NIBS(A_NIBS), .D_NIBS(D_NIBS)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .byte_en (rx_valid),
    .kind    (kind),
    .sh_addr (sh_a),
    .sh_data (sh_d),
    .clr     (clr),
    .is_wr   (req_write),
    .fire    (req_valid)
  );

  hexreq_shift #(.W(ADDR_W)) u_addr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (clr),
    .shift (sh_a),
    .nib   (nib),
    .q     (req_addr)
  );

  hexreq_shift #(.W(DATA_W)) u_data (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (clr),
    .shift (sh_d),
    .nib   (nib),
    .q     (req_wdata)
  );

endmodule

// File: rtl/hexreq_parser_chk.sv
module hexreq_parser_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        rx_byte,
  input logic              rx_valid,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata
);

  // R7: the strobe lasts one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  // R5, R8: a request only follows an accepted line feed
  a_r5_after_lf: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(rx_valid && rx_byte == 8'h0A));

  // R7: the fields were already settled when the line feed arrived
  a_r7_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($stable(req_addr) && $stable(req_wdata) && $stable(req_write)));

  // R3: a read reports zero data
  a_r3_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |-> (req_wdata == '0));

  // R6: an operation letter never completes a request
  a_r6_restart_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && (rx_byte == 8'h52 || rx_byte == 8'h57)) |=> !req_valid);

  // R8: an idle strobe never yields a request
  a_r8_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !req_valid);

endmodule

bind hexreq_parser hexreq_parser_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_byte   (rx_byte),
  .rx_valid  (rx_valid),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata)
);

// File: tb/hexreq_parser_test.sv
`timescale 1ns/1ps
module hexreq_parser_test;

  logic        clk;
  logic        rst_n;
  logic [7:0]  rx_byte;
  logic        rx_valid;
  logic        req_valid;
  logic        req_write;
  logic [15:0] req_addr;
  logic [15:0] req_wdata;

  int total;
  int bad;

  hexreq_parser uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_byte   (rx_byte),
    .rx_valid  (rx_valid),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {byte, expect_valid, expect_write, expect_addr, expect_data}
  localparam int NV = 41;
  localparam logic [41:0] VEC [NV] = '{
    // R2 R3 R7: write 12AB <- 34CD
    {8'h57, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h31, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h32, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h41, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h42, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h33, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h34, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h43, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h44, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h0D, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h0A, 1'b1, 1'b1, 16'h12AB, 16'h34CD},
    // R3: read 0F0F, data zero
    {8'h52, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h30, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h46, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h30, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h46, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h0D, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h0A, 1'b1, 1'b0, 16'h0F0F, 16'h0000},
    // R4: lower-case hex drops the message
    {8'h52, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h61, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h31, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h32, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h0D, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h0A, 1'b0, 1'b0, 16'h0000, 16'h0000},
    // R6: preamble mid-message restarts
    {8'h57, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h31, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h32, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h52, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h39, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h38, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h37, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h36, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h0D, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h0A, 1'b1, 1'b0, 16'h9876, 16'h0000},
    // R5: missing CR; R1: idle junk ignored
    {8'h52, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h31, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h32, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h33, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h34, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h0A, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {8'h0A, 1'b0, 1'b0, 16'h0000, 16'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present a byte for one cycle, then sample the strobe at the next falling edge.
  task automatic send(input logic [7:0] b, input logic v, output logic got);
    @(negedge clk);
    rx_byte  = b;
    rx_valid = v;
    @(negedge clk);
    rx_valid = 1'b0;
    got = req_valid;
  endtask

  task automatic send_str(input string s, output logic got);
    got = 1'b0;
    for (int k = 0; k < s.len(); k++) begin
      logic g;
      send(s[k], 1'b1, g);
      got = g;
    end
  endtask

  task automatic do_reset();
    rst_n    = 1'b0;
    rx_valid = 1'b0;
    rx_byte  = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic g;
    total = 0;
    bad   = 0;
    rst_n    = 1'b0;
    rx_valid = 1'b0;
    rx_byte  = 8'h00;
    #5;
    check("R9 reset strobe low", {31'd0, req_valid}, 32'd0);
    do_reset();
    check("R9 strobe low after release", {31'd0, req_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      v = VEC[i];
      send(v[41:34], 1'b1, g);
      check($sformatf("R7 strobe at vector %0d", i), {31'd0, g}, {31'd0, v[33]});
      if (v[33]) begin
        check("R3 direction", {31'd0, req_write}, {31'd0, v[32]});
        check("R2 address", {16'd0, req_addr}, {16'd0, v[31:16]});
        check("R3 data", {16'd0, req_wdata}, {16'd0, v[15:0]});
        @(negedge clk);
        check("R7 one cycle wide", {31'd0, req_valid}, 32'd0);
      end
    end

    // R1: idle junk then a valid read
    send_str("xZ9\r\n", g);
    check("R1 junk ignored", {31'd0, g}, 32'd0);
    send_str("RFFFF\r\n", g);
    check("R1 read after junk", {31'd0, g}, 32'd1);
    check("R2 address FFFF", {16'd0, req_addr}, 32'h0000FFFF);

    // R8: byte with strobe low must not abort
    send_str("R1", g);
    send(8'h5A, 1'b0, g);
    send(8'h0A, 1'b0, g);
    send_str("234\r\n", g);
    check("R8 strobe-low bytes ignored", {31'd0, g}, 32'd1);
    check("R8 address 1234", {16'd0, req_addr}, 32'h00001234);

    // R5: doubled CR drops the message
    send_str("W0000FFFF\r\r\n", g);
    check("R5 doubled CR", {31'd0, g}, 32'd0);

    // R4: byte just past F drops the message
    send_str("W000G1111\r\n", g);
    check("R4 G rejected", {31'd0, g}, 32'd0);

    // R6: restart from terminator position, write to read
    send_str("W1111AAAA\rR0001\r\n", g);
    check("R6 restart at CR", {31'd0, g}, 32'd1);
    check("R6 direction read", {31'd0, req_write}, 32'd0);
    check("R6 data cleared", {16'd0, req_wdata}, 32'd0);

    // R9: reset mid-message loses it
    send_str("W12", g);
    do_reset();
    send_str("34ABCD\r\n", g);
    check("R9 partial message lost", {31'd0, g}, 32'd0);

    finish_run();
  end

endmodule